// File: doc/BRIEF.md
# Flow-Control Frame Ingress Receiver

This block sits at the receive end of a narrow double-data-rate control link from a switch fabric. It sees one link byte per clock: the upper nibble comes from the rising-edge capture and the lower nibble from the falling-edge capture. A start-of-frame pin marks the first byte of a frame, and an odd-parity pin covers each byte. Every frame carries two fabric-readiness bits in its leading byte. These bits are latched from every intact frame, idle frames included, and they gate the local transmit path, which lies outside this block.

Frames that carry flow-control content are packed into 32-bit words and held in an ingress word FIFO. A host drains the FIFO through a valid/ready stream. A frame becomes visible only once its closing check byte has been verified, so the host never sees part of a frame. When the FIFO holds its full number of committed words, the local control-ready indication returned to the fabric drops. This tells the fabric to stop sending control frames.

The read side follows these back-pressure rules. `out_valid` stays high for as long as any committed word is present. A word leaves the FIFO on a rising clock edge where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, `out_data` holds its value.

Top module: `fc_ingress_rx`

## Requirements
- R1: A frame is a byte sequence. The first byte is flagged by `fc_sof` and holds fabric control-ready in bit 7, fabric data-ready in bit 6 and a frame kind in bits 5:4 (00 means idle). The second byte is the payload length L (0..255). L payload bytes follow, then one check byte equal to the XOR of every earlier byte of the frame. Bytes seen outside a frame have no effect.
- R2: After reset both fabric-ready outputs are 0. An intact frame of any kind loads bits 7:6 of its first byte into `fab_ctl_rdy`/`fab_dat_rdy` on the clock edge that takes its check byte.
- R3: A frame of kind 00 writes nothing into the FIFO.
- R4: A frame of another kind stores a header word {16'h0, first byte, L}. This is followed by ceil(L/4) payload words, with payload byte i at bits 8*(i%4)+7:8*(i%4) of word i/4 and the unused upper bytes of the last word set to zero. None of these words becomes readable before the edge that takes the check byte.
- R5: Every byte must satisfy odd parity, meaning the XOR of the byte and `fc_par` is 1. A frame that has any failing byte, or a check byte that does not match, is dropped whole and its ready bits are not applied. Such a frame also sets `err_parity`, which stays set until reset.
- R6: An `fc_sof` that arrives before a frame's check byte drops the unfinished frame and sets `err_parity`. The byte that carries that `fc_sof` starts a new frame.
- R7: A non-idle frame whose words do not all fit in the free FIFO space is dropped whole and sets `err_overflow`, which stays set until reset. If the frame is otherwise intact, its ready bits are still applied.
- R8: `out_valid` and `fifo_nempty` are high exactly when at least one committed word is held. Words come out in arrival order. A word is removed on an edge where both `out_valid` and `out_ready` are high, and `out_data` is held while `out_valid` is high and `out_ready` is low.
- R9: `fifo_full` is high when DEPTH committed words are held. `loc_ctl_rdy` is its inverse in the same cycle and is 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fc_sof | input | 1 | Marks the first byte of a frame |
| fc_nib_rise | input | 4 | Rising-edge nibble, upper half of the byte |
| fc_nib_fall | input | 4 | Falling-edge nibble, lower half of the byte |
| fc_par | input | 1 | Odd parity bit for the current byte |
| out_valid | output | 1 | A committed word is available |
| out_ready | input | 1 | Host accepts the word this cycle |
| out_data | output | W | Word at the FIFO head |
| fifo_nempty | output | 1 | FIFO holds at least one committed word |
| fifo_full | output | 1 | FIFO holds DEPTH committed words |
| fab_ctl_rdy | output | 1 | Fabric control-ready from the last intact frame |
| fab_dat_rdy | output | 1 | Fabric data-ready from the last intact frame |
| loc_ctl_rdy | output | 1 | Local control-ready returned to the fabric |
| err_parity | output | 1 | Sticky flag for a parity, check byte or truncation fault |
| err_overflow | output | 1 | Sticky flag for a frame dropped for lack of space |

## Verification
The bench goes after frames that corrupt a single byte, including the length and check bytes themselves. A design that committed some words before the check byte, or applied the ready bits anyway, would leave stray words in the FIFO or wrong flags. Lengths of 0 and non-multiples of four test the header-only case and the zero padding of the last word. An off-by-one in the packing would shift bytes or leak stale data. A restart with `fc_sof` in mid-frame, a FIFO filled to exactly its depth, and one frame too many check the rollback and the release of local control-ready. A design that leaked a partial frame, or kept control-ready high while full, would show up there. Holding `out_ready` low checks that the head word does not move under back-pressure.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_LEN, ST_PAY, ST_CHK} rx_state_e;

  localparam int unsigned CRDY_BIT = 7;
  localparam int unsigned DRDY_BIT = 6;
  localparam int unsigned KIND_LSB = 4;

  function automatic logic odd_par_ok(input logic [7:0] b, input logic p);
    return ^{b, p};
  endfunction
endpackage

// File: rtl/fcr_deframer.sv
module fcr_deframer
  import fcr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sof,
  input  logic [7:0]   rx_byte,
  input  logic         par,
  input  logic         room,
  output logic         wr_en,
  output logic [W-1:0] wr_word,
  output logic         commit,
  output logic         abort,
  output logic         rdy_upd,
  output logic [1:0]   rdy_val,
  output logic         par_evt,
  output logic         ovf_evt
);
  localparam int BPW = W / 8;
  localparam int BW  = $clog2(BPW);

  rx_state_e       state_q;
  logic [7:0]      hdr_q, len_q, vx_q;
  logic [W-1:0]    acc_q, merged;
  logic [BW-1:0]   bidx_q;
  logic            herr_q, ovf_q, need_wr, hp_ok, is_data, bad;

  assign hp_ok   = odd_par_ok(rx_byte, par);
  assign is_data = hdr_q[KIND_LSB+1:KIND_LSB] != 2'b00;
  assign rdy_val = {hdr_q[CRDY_BIT], hdr_q[DRDY_BIT]};

  always_comb begin
    merged = acc_q;
    merged[{bidx_q, 3'b000} +: 8] = rx_byte;
    need_wr = 1'b0;
    wr_word = '0;
    commit  = 1'b0;
    abort   = 1'b0;
    rdy_upd = 1'b0;
    par_evt = 1'b0;
    ovf_evt = 1'b0;
    bad     = herr_q | ~hp_ok | (rx_byte != vx_q);
    if (sof) begin
      if (state_q != ST_IDLE) begin
        abort   = 1'b1;
        par_evt = 1'b1;
      end
    end else begin
      case (state_q)
        ST_LEN: if (is_data) begin
          need_wr = 1'b1;
          wr_word = {{(W-16){1'b0}}, hdr_q, rx_byte};
        end
        ST_PAY: if (is_data && (bidx_q == BW'(BPW-1) || len_q == 8'd1)) begin
          need_wr = 1'b1;
          wr_word = merged;
        end
        ST_CHK: begin
          if (bad) begin
            abort   = 1'b1;
            par_evt = 1'b1;
          end else begin
            rdy_upd = 1'b1;
            if (is_data) begin
              if (ovf_q) begin
                abort   = 1'b1;
                ovf_evt = 1'b1;
              end else begin
                commit = 1'b1;
              end
            end
          end
        end
        default: ;
      endcase
    end
    wr_en = need_wr & room & ~ovf_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      hdr_q   <= '0;
      len_q   <= '0;
      vx_q    <= '0;
      acc_q   <= '0;
      bidx_q  <= '0;
      herr_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else if (sof) begin
      state_q <= ST_LEN;
      hdr_q   <= rx_byte;
      vx_q    <= rx_byte;
      herr_q  <= ~hp_ok;
      ovf_q   <= 1'b0;
      acc_q   <= '0;
      bidx_q  <= '0;
    end else begin
      case (state_q)
        ST_LEN: begin
          len_q   <= rx_byte;
          vx_q    <= vx_q ^ rx_byte;
          herr_q  <= herr_q | ~hp_ok;
          ovf_q   <= ovf_q | (need_wr & ~room);
          state_q <= (rx_byte == 8'd0) ? ST_CHK : ST_PAY;
        end
        ST_PAY: begin
          vx_q   <= vx_q ^ rx_byte;
          herr_q <= herr_q | ~hp_ok;
          len_q  <= len_q - 8'd1;
          if (need_wr) begin
            acc_q  <= '0;
            bidx_q <= '0;
            ovf_q  <= ovf_q | ~room;
          end else begin
            acc_q  <= merged;
            bidx_q <= bidx_q + BW'(1);
          end
          if (len_q == 8'd1) state_q <= ST_CHK;
        end
        ST_CHK:  state_q <= ST_IDLE;
        default: ;
      endcase
    end
  end

  // R5
  commit_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(commit && abort));
endmodule

// File: rtl/fcr_word_fifo.sv
module fcr_word_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_word,
  input  logic         commit,
  input  logic         abort,
  output logic         room,
  output logic         rd_valid,
  input  logic         rd_ready,
  output logic [W-1:0] rd_data,
  output logic         nempty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] DEPTH_P = (AW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wt_q, wc_q, rd_q;
  logic         pop;

  assign room     = (wt_q - rd_q) != DEPTH_P;
  assign full     = (wc_q - rd_q) == DEPTH_P;
  assign nempty   = wc_q != rd_q;
  assign rd_valid = nempty;
  assign rd_data  = mem[rd_q[AW-1:0]];
  assign pop      = rd_valid & rd_ready;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wt_q[AW-1:0]] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wt_q <= '0;
      wc_q <= '0;
      rd_q <= '0;
    end else begin
      if (abort)      wt_q <= wc_q;
      else if (wr_en) wt_q <= wt_q + 1'b1;
      if (commit)     wc_q <= wt_q;
      if (pop)        rd_q <= rd_q + 1'b1;
    end
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> room);
  // R8
  head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));
  // R9
  full_nempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> nempty);
  // R4
  commit_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> nempty);
endmodule

// File: rtl/fc_ingress_rx.sv
module fc_ingress_rx #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         fc_sof,
  input  logic [3:0]   fc_nib_rise,
  input  logic [3:0]   fc_nib_fall,
  input  logic         fc_par,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data,
  output logic         fifo_nempty,
  output logic         fifo_full,
  output logic         fab_ctl_rdy,
  output logic         fab_dat_rdy,
  output logic         loc_ctl_rdy,
  output logic         err_parity,
  output logic         err_overflow
);
  logic         wr_en, commit, abort, room, rdy_upd, par_evt, ovf_evt;
  logic [W-1:0] wr_word;
  logic [1:0]   rdy_val;

  fcr_deframer #(.W(W)) i_deframer (
    .clk     (clk),
    .rst_n   (rst_n),
    .sof     (fc_sof),
    .rx_byte ({fc_nib_rise, fc_nib_fall}),
    .par     (fc_par),
    .room    (room),
    .wr_en   (wr_en),
    .wr_word (wr_word),
    .commit  (commit),
    .abort   (abort),
    .rdy_upd (rdy_upd),
    .rdy_val (rdy_val),
    .par_evt (par_evt),
    .ovf_evt (ovf_evt)
  );

  fcr_word_fifo #(.W(W), .DEPTH(DEPTH)) i_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_word  (wr_word),
    .commit   (commit),
    .abort    (abort),
    .room     (room),
    .rd_valid (out_valid),
    .rd_ready (out_ready),
    .rd_data  (out_data),
    .nempty   (fifo_nempty),
    .full     (fifo_full)
  );

  assign loc_ctl_rdy = ~fifo_full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fab_ctl_rdy  <= 1'b0;
      fab_dat_rdy  <= 1'b0;
      err_parity   <= 1'b0;
      err_overflow <= 1'b0;
    end else begin
      if (rdy_upd) {fab_ctl_rdy, fab_dat_rdy} <= rdy_val;
      if (par_evt) err_parity   <= 1'b1;
      if (ovf_evt) err_overflow <= 1'b1;
    end
  end

  // R5
  sticky_par_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_parity |=> err_parity);
  // R7
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_overflow |=> err_overflow);
endmodule

// File: tb/test_fc_ingress_rx.sv
`timescale 1ns/1ps
module test_fc_ingress_rx;
  localparam int W = 32;
  localparam int DEPTH = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fc_sof = 1'b0, fc_par = 1'b1, out_ready = 1'b0;
  logic [3:0] fc_nib_rise = '0, fc_nib_fall = '0;
  logic out_valid, fifo_nempty, fifo_full, fab_ctl_rdy, fab_dat_rdy;
  logic loc_ctl_rdy, err_parity, err_overflow;
  logic [W-1:0] out_data;

  int tests = 0, fails = 0;
  logic [1:0] exp_fab = 2'b00;
  logic exp_perr = 1'b0, exp_oerr = 1'b0;
  logic [31:0] exp_q [$];

  always #4 clk = ~clk;

  fc_ingress_rx #(.W(W), .DEPTH(DEPTH)) i_fc_ingress_rx (
    .clk(clk), .rst_n(rst_n), .fc_sof(fc_sof), .fc_nib_rise(fc_nib_rise),
    .fc_nib_fall(fc_nib_fall), .fc_par(fc_par), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .fifo_nempty(fifo_nempty),
    .fifo_full(fifo_full), .fab_ctl_rdy(fab_ctl_rdy), .fab_dat_rdy(fab_dat_rdy),
    .loc_ctl_rdy(loc_ctl_rdy), .err_parity(err_parity), .err_overflow(err_overflow));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] xor_all(input logic [7:0] fb[$]);
    logic [7:0] x = 8'h00;
    foreach (fb[i]) x ^= fb[i];
    return x;
  endfunction

  task automatic put(input logic [7:0] b, input logic s, input logic badp);
    @(negedge clk);
    fc_sof = s;
    {fc_nib_rise, fc_nib_fall} = b;
    fc_par = ~(^b) ^ badp;
  endtask

  task automatic idle_cycle();
    logic [7:0] junk;
    @(negedge clk);
    junk = 8'($urandom);
    fc_sof = 1'b0;
    {fc_nib_rise, fc_nib_fall} = junk;
    fc_par = ~(^junk);
  endtask

  task automatic post_checks();
    check("R2 fabric ready bits", {30'd0, fab_ctl_rdy, fab_dat_rdy}, {30'd0, exp_fab});
    check("R5 err_parity", {31'd0, err_parity}, {31'd0, exp_perr});
    check("R7 err_overflow", {31'd0, err_overflow}, {31'd0, exp_oerr});
    check("R8 fifo_nempty", {31'd0, fifo_nempty}, {31'd0, exp_q.size() > 0});
    check("R9 fifo_full", {31'd0, fifo_full}, {31'd0, exp_q.size() == DEPTH});
    check("R9 loc_ctl_rdy", {31'd0, loc_ctl_rdy}, {31'd0, exp_q.size() != DEPTH});
  endtask

  // mode: 0 intact, 1 one byte with bad parity, 2 wrong check byte
  // trunc_at > 0: only that many bytes are sent and the next frame follows at once
  task automatic send_frame(input logic [1:0] rdy, input logic [1:0] kind, input int len,
                            input int mode, input int trunc_at);
    logic [7:0] fb[$];
    logic [7:0] pl[$];
    logic [31:0] words[$];
    int badpos, n, nw;
    fb.push_back({rdy, kind, 4'h0});
    fb.push_back(8'(len));
    for (int i = 0; i < len; i++) begin
      pl.push_back(8'($urandom));
      fb.push_back(pl[i]);
    end
    fb.push_back(xor_all(fb) ^ ((mode == 2) ? 8'h01 : 8'h00));
    badpos = (mode == 1) ? $urandom_range(0, fb.size() - 1) : -1;
    n = (trunc_at > 0) ? trunc_at : fb.size();
    for (int i = 0; i < n; i++) put(fb[i], i == 0, i == badpos);
    if (trunc_at > 0) begin
      exp_perr = 1'b1;
      return;
    end
    if (mode != 0) begin
      exp_perr = 1'b1;
    end else begin
      exp_fab = rdy;
      if (kind != 2'b00) begin
        words.push_back({16'h0, fb[0], fb[1]});
        nw = (len + 3) / 4;
        for (int w = 0; w < nw; w++) begin
          logic [31:0] wd = '0;
          for (int j = 0; j < 4; j++)
            if (4 * w + j < len) wd[8*j +: 8] = pl[4 * w + j];
          words.push_back(wd);
        end
        if (exp_q.size() + words.size() > DEPTH) exp_oerr = 1'b1;
        else foreach (words[k]) exp_q.push_back(words[k]);
      end
    end
    idle_cycle();
    post_checks();
  endtask

  task automatic drain();
    for (int g = 0; g < 4 * DEPTH + 8; g++) begin
      @(negedge clk);
      if (!out_valid) break;
      if (exp_q.size() == 0) begin
        check("R8 unexpected word", out_data, 32'hx);
        out_ready = 1'b1;
      end else begin
        check("R4 word content", out_data, exp_q.pop_front());
        out_ready = 1'b1;
      end
    end
    out_ready = 1'b0;
    check("R8 drained", {31'd0, out_valid}, 32'd0);
    check("R4 expected words consumed", exp_q.size(), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] head;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R2 R9 reset state
    post_checks();
    check("R8 out_valid after reset", {31'd0, out_valid}, 32'd0);

    // R1 bytes outside a frame do nothing
    repeat (5) idle_cycle();
    post_checks();

    // R2 R3 idle frame updates ready bits only
    send_frame(2'b11, 2'b00, 0, 0, 0);
    send_frame(2'b10, 2'b00, 3, 0, 0);

    // R4 data frames: padding and header-only
    send_frame(2'b01, 2'b01, 5, 0, 0);
    drain();
    send_frame(2'b11, 2'b10, 0, 0, 0);
    drain();
    send_frame(2'b00, 2'b11, 8, 0, 0);
    drain();

    // R5 parity and check byte faults
    send_frame(2'b11, 2'b01, 7, 1, 0);
    check("R5 dropped frame leaves FIFO empty", {31'd0, out_valid}, 32'd0);
    send_frame(2'b10, 2'b01, 2, 2, 0);
    send_frame(2'b01, 2'b00, 0, 2, 0);
    drain();

    // R6 truncation by a new start of frame
    send_frame(2'b11, 2'b01, 9, 0, 6);
    send_frame(2'b10, 2'b01, 3, 0, 0);
    drain();
    send_frame(2'b01, 2'b10, 4, 0, 1);
    send_frame(2'b11, 2'b00, 0, 0, 0);
    drain();

    // R9 fill exactly, R7 one frame too many
    for (int f = 0; f < 4; f++) send_frame(2'b01, 2'b01, 12, 0, 0);
    check("R9 full at depth", {31'd0, fifo_full}, 32'd1);
    check("R9 local ready low when full", {31'd0, loc_ctl_rdy}, 32'd0);
    send_frame(2'b10, 2'b01, 0, 0, 0);
    check("R7 overflow flag", {31'd0, err_overflow}, 32'd1);
    check("R7 ready bits applied", {30'd0, fab_ctl_rdy, fab_dat_rdy}, 32'd2);

    // R8 head held under back-pressure
    @(negedge clk);
    head = out_data;
    repeat (3) @(negedge clk);
    check("R8 head stable", out_data, head);
    check("R8 valid stable", {31'd0, out_valid}, 32'd1);
    drain();
    check("R9 local ready back", {31'd0, loc_ctl_rdy}, 32'd1);

    // R7 single frame larger than the FIFO
    send_frame(2'b11, 2'b01, 80, 0, 0);
    drain();

    // random mix
    for (int r = 0; r < 60; r++) begin
      logic [1:0] kind = 2'($urandom_range(0, 3));
      int len = (kind == 2'b00) ? (($urandom_range(0, 3) == 0) ? 2 : 0) : $urandom_range(0, 40);
      int sel = $urandom_range(0, 11);
      int mode = (sel == 0) ? 1 : (sel == 1) ? 2 : 0;
      if (sel == 2) begin
        send_frame(2'($urandom), kind, len, 0, $urandom_range(1, len + 2));
        send_frame(2'($urandom), 2'b01, 1, 0, 0);
      end else begin
        send_frame(2'($urandom), kind, len, mode, 0);
      end
      if ($urandom_range(0, 1) == 1) drain();
    end
    drain();

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule